// File: doc/BRIEF.md
# Bit-Serial Adder with Mealy Carry Machine

This block adds two unsigned operands of `WIDTH` bits using one bit position per clock cycle, starting from the least significant bit. When a start command arrives while the block is idle, it loads both operands into shift registers. On each of the following `WIDTH` cycles, the lowest bit of each operand register feeds a two-state machine whose state is the running carry. The sum bit that machine produces is shifted into a result register.

The sum bit is a Mealy output. It depends on the current carry state and on the two operand bits presented in the same cycle, so no extra cycle is spent per bit. The block trades area for time: a single bit slice and three shift registers replace a full-width adder. It suits slow control paths where `WIDTH` cycles per addition are acceptable.

Top module: `serial_adder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `busy`, `done`, `sum_out` and `carry_out` to 0.
- R2: A `start` sampled high while `busy` is 0 loads `op_a` and `op_b`, forces the carry state to 0 (`carry_out` reads 0) and raises `busy` from the next cycle.
- R3: In carry state 0 the machine moves to carry state 1 only when both operand bits are 1. In carry state 1 it returns to state 0 only when both operand bits are 0. Otherwise the state holds.
- R4: The sum bit is the operand bits' XOR in carry state 0 and its inverse in carry state 1. Each sum bit enters `sum_out` at bit `WIDTH-1` while the register shifts right, so after the run bit 0 holds the first bit computed.
- R5: `busy` stays high for exactly `WIDTH` cycles after the accepting edge. `done` is high for one cycle only, the first cycle in which `busy` is low again.
- R6: When `done` is high, `sum_out` equals `(op_a + op_b) mod 2^WIDTH` and `carry_out` equals bit `WIDTH` of `op_a + op_b`. Both hold their values until the next accepted start or reset.
- R7: A `start` while `busy` is 1 is ignored. The running addition finishes with its original operands and timing.
- R8: A `start` in the cycle `done` is high is accepted, so additions may run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition when idle |
| op_a | input | WIDTH | First operand, sampled on an accepted start |
| op_b | input | WIDTH | Second operand, sampled on an accepted start |
| sum_out | output | WIDTH | Result register |
| carry_out | output | 1 | Carry state; final carry after a run |
| busy | output | 1 | High while bits are being shifted |
| done | output | 1 | One-cycle completion pulse |

## Verification
Assertions check on every cycle that the carry machine keeps its state unless the operand bits call for a change, and that a start while busy neither stops the run nor disturbs the operand shift. They also check that `done` is a single pulse that follows busy time, and that the result and carry hold steady while idle. Only the bench's scenarios can show that the shifted bits assemble into the correct full sum and carry-out. The scenarios cover a vector table, random operands, carry chains across every bit, back-to-back starts and a reset in the middle of a run.

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic {CARRY_LO = 1'b0, CARRY_HI = 1'b1} carry_t;

  carry_t           cst, cnx;
  logic [WIDTH-1:0] opa_q, opb_q, res_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q, sbit;

  wire abit   = opa_q[0];
  wire bbit   = opb_q[0];
  wire accept = start & ~busy_q;

  always_comb begin
    cnx  = cst;
    sbit = abit ^ bbit;
    case (cst)
      CARRY_LO: begin
        if (abit && bbit) cnx = CARRY_HI;
        sbit = abit ^ bbit;
      end
      CARRY_HI: begin
        if (!abit && !bbit) cnx = CARRY_LO;
        sbit = ~(abit ^ bbit);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cst    <= CARRY_LO;
      opa_q  <= '0;
      opb_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        opa_q  <= op_a;
        opb_q  <= op_b;
        res_q  <= '0;
        cst    <= CARRY_LO;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        opa_q <= opa_q >> 1;
        opb_q <= opb_q >> 1;
        res_q <= {sbit, res_q[WIDTH-1:1]};
        cst   <= cnx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sum_out   = res_q;
  assign carry_out = (cst == CARRY_HI);
  assign busy      = busy_q;
  assign done      = done_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !busy && !done && carry_out == 1'b0 && sum_out == '0);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !carry_out && opa_q == $past(op_a));

  assert_lo_holds_R3: assert property (@(posedge clk) disable iff (rst)
    busy && !start && cst == CARRY_LO && !(abit && bbit) |=> cst == CARRY_LO);

  assert_hi_holds_R3: assert property (@(posedge clk) disable iff (rst)
    busy && cst == CARRY_HI && (abit || bbit) |=> cst == CARRY_HI);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(sum_out) && $stable(carry_out));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    busy && start && cnt_q != LAST |=> busy && opa_q == ($past(opa_q) >> 1));
endmodule

// File: tb/serial_adder_bench.sv
module serial_adder_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, start;
  logic [W-1:0] op_a, op_b, sum_out;
  logic         carry_out, busy, done;
  int           checks = 0, errors = 0;

  localparam logic [2*W-1:0] VEC [8] = '{
    16'h0000, 16'hFF01, 16'hFFFF, 16'h8080,
    16'h5555, 16'hAA55, 16'h0F01, 16'h7F01
  };

  serial_adder #(.WIDTH(W)) u_serial_adder (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .sum_out(sum_out), .carry_out(carry_out), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !carry_out, "R2 busy after start", {busy, done, carry_out}, 3'b100);
  endtask

  task automatic finish(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string req);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin op_a = ~a; op_b = 8'h33; start = 1'b1; end
      if (poke && i == 3) start = 1'b0;
      check(busy && !done, "R5 busy window", {busy, done}, 2'b10);
    end
    @(negedge clk);
    check(done && !busy, "R5 done pulse", {done, busy}, 2'b10);
    check(sum_out == exp[W-1:0], {req, " R6 sum"}, sum_out, exp[W-1:0]);
    check(carry_out == exp[W], {req, " R6 carry"}, carry_out, exp[W]);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && sum_out == 0 && !carry_out, "R1 reset state", {busy, done, carry_out}, 0);

    // table of operand pairs: carry chains for R3, sum bits for R4
    foreach (VEC[k]) begin
      launch(VEC[k][2*W-1:W], VEC[k][W-1:0]);
      finish(VEC[k][2*W-1:W], VEC[k][W-1:0], 1'b0, "R3 R4 vector");
      @(negedge clk);
    end

    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom); rb = W'($urandom);
      launch(ra, rb);
      finish(ra, rb, 1'b0, "R4 random");
      @(negedge clk);
    end

    // idle hold after completion
    launch(8'hC3, 8'h5A);
    finish(8'hC3, 8'h5A, 1'b0, "R6 hold setup");
    keep = sum_out;
    repeat (3) @(negedge clk);
    check(sum_out == keep && carry_out && !done && !busy, "R6 idle hold", sum_out, keep);

    // start during busy ignored
    launch(8'hFF, 8'h01);
    finish(8'hFF, 8'h01, 1'b1, "R7 start while busy");
    @(negedge clk);

    // back-to-back start on done cycle
    launch(8'h12, 8'h34);
    finish(8'h12, 8'h34, 1'b0, "R8 first");
    launch(8'hF0, 8'h1F);
    finish(8'hF0, 8'h1F, 1'b0, "R8 second");
    @(negedge clk);

    // reset mid-run
    launch(8'hFF, 8'hFF);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && sum_out == 0 && !carry_out, "R1 reset mid-run", {busy, done, sum_out}, 0);
    repeat (W + 1) @(negedge clk);
    check(!done && !busy, "R1 no late done", {done, busy}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule